// File: doc/BRIEF.md
# Monochrome Raster Scanout Engine

This block generates the raster timing for a 1-bit-per-pixel monochrome display. It also turns a framebuffer in DRAM into a serial pixel stream. It runs from one pixel clock and keeps a signed horizontal position and a signed vertical position. Both positions are negative during blanking and reach zero on the first visible pixel and the first visible line.

Two active-low sync pulses are decoded from the positions. For each 16 pixels of a visible line the block fetches one 16-bit word over a plain request/acknowledge/data port. The returned word goes into a shifter that sends out the most significant bit first.

The framebuffer base is the installed RAM size minus a fixed offset. A main offset and an alternate offset are available, and a page-select input picks between them. The RAM size code and the page select are latched once per frame, so a change in the middle of a frame never tears the picture. A DRAM controller outside this block serves the fetch port.

Top module: `vscan_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `h_pos` = -H_BLANK, `v_pos` = -V_BLANK, `hsync_n` = 1, `vsync_n` = 1, `pix_out` = 0 and `fetch_req` = 0.
- R2: `h_pos` steps by one per clock from -H_BLANK to H_VIS-1, then wraps to -H_BLANK. On that wrap `v_pos` advances by one.
- R3: `v_pos` runs from -V_BLANK to V_VIS-1 and then wraps. A frame is (H_VIS+H_BLANK)*(V_VIS+V_BLANK) clocks.
- R4: `hsync_n` is 0 exactly when h_pos lies in [-H_BLANK+HS_OFS, -H_BLANK+HS_OFS+HS_W). `vsync_n` is 0 exactly when v_pos lies in [-V_BLANK+VS_OFS, -V_BLANK+VS_OFS+VS_W).
- R5: The framebuffer byte base is size minus offset. The main offset is MAIN_OFS (0x5900) and the alternate offset is ALT_OFS (0xD900). The `ram_size` codes are: 0=0x20000, 1=0x40000, 2=0x80000, 3=0x100000, 4=0x200000, 5=0x280000, 6 and 7=0x400000.
- R6: `page_main`=1 selects the main base and 0 selects the alternate base. `page_main` and `ram_size` are latched only on the clock edge that enters line v_pos=0. Changes at any other time have no effect until the next frame.
- R7: On visible lines, `fetch_req` rises in the cycle where h_pos = 16k-16, for k = 0..H_VIS/16-1, with `fetch_addr` = base + 2*(v_pos*H_VIS/16 + k). Both hold until the clock edge that samples `fetch_ack`=1, and `fetch_req` is 0 in the next cycle.
- R8: During one frame, every word address from base to base + 2*(H_VIS/16*V_VIS - 1) is requested exactly once, in ascending order.
- R9: In a visible cycle, `pix_out` is bit (15 - h_pos mod 16) of the word for that position. Bit 15 is the leftmost pixel. The acknowledge may arrive 1 to 16 cycles after the request rises, including on the edge where the word enters the shifter.
- R10: `pix_out` is 0 whenever h_pos < 0 or v_pos < 0. No request is issued during vertical blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_size | input | 3 | Installed RAM size code (see R5) |
| page_main | input | 1 | 1 = main buffer, 0 = alternate buffer |
| fetch_ack | input | 1 | Fetch completion; `fetch_data` is valid in the same cycle |
| fetch_data | input | 16 | Returned framebuffer word |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | 24 | Byte address of the requested word |
| pix_out | output | 1 | Serial pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| h_pos | output | HW | Signed horizontal position |
| v_pos | output | VW | Signed vertical position |

## Verification
Positions, syncs and the pixel output are all due in the same cycle as the bench's cycle index. The index counts from the first clock after reset, so each negative-edge sample compares against the position computed from that index. A request is due in the cycle h_pos reaches 16k-16. It must drop one cycle after the acknowledging edge, and the bench's fetch model follows that with an outstanding flag. Acknowledge latency is swept from 1 to 16 cycles, so the latest case lands on the very edge that loads the shifter. The bench latches the page and size itself at the line-0 entry and changes them only in line 1, which makes every mid-frame change one that must be ignored.

// File: rtl/vscan_pkg.sv
// Shared constants and helpers for the raster scanout engine.
package vscan_pkg;
    localparam int ADDR_W = 24;

    // Installed RAM size in bytes for a 3-bit size code.
    function automatic logic [ADDR_W-1:0] ram_bytes(input logic [2:0] code);
        logic [ADDR_W-1:0] r;
        if (code < 3'd5)
            r = ADDR_W'(24'h020000) << code;
        else if (code == 3'd5)
            r = 24'h280000;
        else
            r = 24'h400000;
        return r;
    endfunction
endpackage

// File: rtl/vscan_raster.sv
// Raster position counters and sync decode.
// Assumes: H_BLANK > HS_OFS+HS_W, V_BLANK > VS_OFS+VS_W, HS_OFS and VS_OFS >= 1.
// Positions are signed: negative in blanking, zero at the visible start.
module vscan_raster #(
    parameter int H_VIS   = 512,
    parameter int H_BLANK = 192,
    parameter int V_VIS   = 342,
    parameter int V_BLANK = 28,
    parameter int HS_OFS  = 16,
    parameter int HS_W    = 48,
    parameter int VS_OFS  = 2,
    parameter int VS_W    = 4,
    parameter int HW      = 11,
    parameter int VW      = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic signed [HW-1:0] hpos,
    output logic signed [VW-1:0] vpos,
    output logic                 hsync_n,
    output logic                 vsync_n
);
    localparam int H_FIRST = -H_BLANK;
    localparam int V_FIRST = -V_BLANK;
    localparam int HS_LO   = H_FIRST + HS_OFS;
    localparam int HS_HI   = HS_LO + HS_W;
    localparam int VS_LO   = V_FIRST + VS_OFS;
    localparam int VS_HI   = VS_LO + VS_W;

    // Advance the pixel position, and the line position on line wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= HW'(H_FIRST);
            vpos <= VW'(V_FIRST);
        end else if (int'(hpos) == H_VIS - 1) begin
            hpos <= HW'(H_FIRST);
            if (int'(vpos) == V_VIS - 1)
                vpos <= VW'(V_FIRST);
            else
                vpos <= vpos + 1'b1;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end

    // Sync pulses are windows inside the blanking intervals.
    always_comb begin
        hsync_n = !(int'(hpos) >= HS_LO && int'(hpos) < HS_HI);
        vsync_n = !(int'(vpos) >= VS_LO && int'(vpos) < VS_HI);
    end
endmodule

// File: rtl/vscan_fetch.sv
// Framebuffer fetch sequencer.
// Latches the buffer base (RAM size minus page offset) when line 0 is entered.
// Raises one request per word, 16 clocks before the word enters the shifter.
// Assumes: the memory side acknowledges within 16 cycles; H_BLANK > WORD_W.
module vscan_fetch
    import vscan_pkg::*;
#(
    parameter int H_VIS    = 512,
    parameter int V_VIS    = 342,
    parameter int WORD_W   = 16,
    parameter int MAIN_OFS = 'h5900,
    parameter int ALT_OFS  = 'hD900,
    parameter int HW       = 11,
    parameter int VW       = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [HW-1:0]  hpos,
    input  logic signed [VW-1:0]  vpos,
    input  logic [2:0]            ram_size,
    input  logic                  page_main,
    input  logic                  fetch_ack,
    output logic                  fetch_req,
    output logic [ADDR_W-1:0]     fetch_addr
);
    localparam int LW     = $clog2(WORD_W);
    localparam int WORDS  = (H_VIS / WORD_W) * V_VIS;
    localparam int IW     = $clog2(WORDS + 1);
    localparam int ISS_LO = -(WORD_W + 1);
    localparam int ISS_HI = H_VIS - 2 * WORD_W - 1;

    logic              issue;
    logic              frame_start;
    logic [ADDR_W-1:0] base_q;
    logic [IW-1:0]     widx;

    // Decode the request slot and the line-0 entry edge.
    always_comb begin
        issue = (vpos >= 0) && (&hpos[LW-1:0]) &&
                int'(hpos) >= ISS_LO && int'(hpos) <= ISS_HI;
        frame_start = int'(hpos) == H_VIS - 1 && int'(vpos) == -1;
    end

    // Latch the frame's buffer base once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (frame_start)
            base_q <= ram_bytes(ram_size) -
                      (page_main ? ADDR_W'(MAIN_OFS) : ADDR_W'(ALT_OFS));
    end

    // Word index within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)
            widx <= '0;
        else if (issue)
            widx <= widx + 1'b1;
    end

    // Request flag and address: set on a slot, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
        end else if (issue) begin
            fetch_req  <= 1'b1;
            fetch_addr <= base_q + ADDR_W'({widx, 1'b0});
        end else if (fetch_ack) begin
            fetch_req  <= 1'b0;
        end
    end
endmodule

// File: rtl/vscan_shifter.sv
// Pixel shifter with a one-word holding register.
// A word acknowledged on the load edge itself bypasses the holding register.
// The output is gated to 0 outside the visible area.
module vscan_shifter #(
    parameter int H_VIS  = 512,
    parameter int WORD_W = 16,
    parameter int HW     = 11,
    parameter int VW     = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [HW-1:0] hpos,
    input  logic signed [VW-1:0] vpos,
    input  logic                 fetch_ack,
    input  logic [WORD_W-1:0]    fetch_data,
    output logic                 pix_out
);
    localparam int LW = $clog2(WORD_W);

    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sh_q;
    logic              load;

    // Load when the next pixel starts a visible word.
    always_comb begin
        load = (vpos >= 0) && (&hpos[LW-1:0]) &&
               int'(hpos) >= -1 && int'(hpos) <= H_VIS - 2;
        pix_out = (hpos >= 0) && (vpos >= 0) && sh_q[WORD_W-1];
    end

    // Capture each returned word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (fetch_ack)
            hold_q <= fetch_data;
    end

    // Shift left one pixel per clock, reloading at word boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= fetch_ack ? fetch_data : hold_q;
        else
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
endmodule

// File: rtl/vscan_top.sv
// Raster scanout engine top: counters, fetch sequencer and pixel shifter.
// Assumes a single pixel clock and a memory port acknowledging within 16 cycles.
module vscan_top
    import vscan_pkg::*;
#(
    parameter int H_VIS    = 512,
    parameter int H_BLANK  = 192,
    parameter int V_VIS    = 342,
    parameter int V_BLANK  = 28,
    parameter int HS_OFS   = 16,
    parameter int HS_W     = 48,
    parameter int VS_OFS   = 2,
    parameter int VS_W     = 4,
    parameter int MAIN_OFS = 'h5900,
    parameter int ALT_OFS  = 'hD900,
    localparam int WORD_W  = 16,
    localparam int HW      = $clog2(H_VIS + H_BLANK) + 1,
    localparam int VW      = $clog2(V_VIS + V_BLANK) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            ram_size,
    input  logic                  page_main,
    input  logic                  fetch_ack,
    input  logic [WORD_W-1:0]     fetch_data,
    output logic                  fetch_req,
    output logic [ADDR_W-1:0]     fetch_addr,
    output logic                  pix_out,
    output logic                  hsync_n,
    output logic                  vsync_n,
    output logic signed [HW-1:0]  h_pos,
    output logic signed [VW-1:0]  v_pos
);
    vscan_raster #(
        .H_VIS(H_VIS), .H_BLANK(H_BLANK), .V_VIS(V_VIS), .V_BLANK(V_BLANK),
        .HS_OFS(HS_OFS), .HS_W(HS_W), .VS_OFS(VS_OFS), .VS_W(VS_W),
        .HW(HW), .VW(VW)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .hpos(h_pos), .vpos(v_pos),
        .hsync_n(hsync_n), .vsync_n(vsync_n)
    );

    vscan_fetch #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .WORD_W(WORD_W),
        .MAIN_OFS(MAIN_OFS), .ALT_OFS(ALT_OFS), .HW(HW), .VW(VW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .hpos(h_pos), .vpos(v_pos),
        .ram_size(ram_size), .page_main(page_main), .fetch_ack(fetch_ack),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    vscan_shifter #(
        .H_VIS(H_VIS), .WORD_W(WORD_W), .HW(HW), .VW(VW)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .hpos(h_pos), .vpos(v_pos),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .pix_out(pix_out)
    );
endmodule

// File: rtl/vscan_checker.sv
// Protocol and timing properties of the scanout engine, bound to vscan_top.
module vscan_checker #(
    parameter int H_VIS   = 512,
    parameter int V_VIS   = 342,
    parameter int V_BLANK = 28,
    parameter int HW      = 11,
    parameter int VW      = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic signed [HW-1:0] h_pos,
    input logic signed [VW-1:0] v_pos,
    input logic                 fetch_req,
    input logic                 fetch_ack,
    input logic [23:0]          fetch_addr,
    input logic                 pix_out,
    input logic                 hsync_n
);
    // R2: position steps by one except at the line end
    assert_hstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_pos) != H_VIS - 1) |=> (h_pos == HW'($past(h_pos) + 1'b1)));

    // R3: line position stays within its range
    assert_vrange_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(v_pos) >= -V_BLANK && int'(v_pos) < V_VIS));

    // R4: horizontal sync only inside horizontal blanking
    assert_sync_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> (h_pos < 0));

    // R7: request and address held until acknowledged
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

    // R7: request drops after the acknowledging edge
    assert_req_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack) |=> !fetch_req);

    // R10: dark output during blanking
    assert_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos < 0 || v_pos < 0) |-> !pix_out);

    // R10: no fetches during vertical blanking
    assert_no_vblank_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_pos < 0) |-> !fetch_req);
endmodule

bind vscan_top vscan_checker #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .V_BLANK(V_BLANK), .HW(HW), .VW(VW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
    .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_addr(fetch_addr),
    .pix_out(pix_out), .hsync_n(hsync_n)
);

// File: tb/vscan_top_test.sv
module vscan_top_test;
    localparam int H_VIS = 32, H_BLANK = 24, V_VIS = 4, V_BLANK = 3;
    localparam int HS_OFS = 2, HS_W = 4, VS_OFS = 1, VS_W = 1;
    localparam int HW = $clog2(H_VIS + H_BLANK) + 1;
    localparam int VW = $clog2(V_VIS + V_BLANK) + 1;
    localparam int LINE = H_VIS + H_BLANK;
    localparam int VTOT = V_VIS + V_BLANK;
    localparam int WPL = H_VIS / 16;
    localparam int FRAMES = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] ram_size = 3'd3;
    logic page_main = 1'b1;
    logic fetch_ack = 1'b0;
    logic [15:0] fetch_data = '0;
    logic fetch_req, pix_out, hsync_n, vsync_n;
    logic [23:0] fetch_addr;
    logic signed [HW-1:0] h_pos;
    logic signed [VW-1:0] v_pos;

    int total = 0, bad = 0;
    bit running = 0, finished = 0;
    int t = 0, fr = 0, acks = 0, wcnt = 0, lat = 1, exp_idx = 0;
    bit outstanding = 0, seen = 0;
    logic [23:0] fbase = '0;

    vscan_top #(
        .H_VIS(H_VIS), .H_BLANK(H_BLANK), .V_VIS(V_VIS), .V_BLANK(V_BLANK),
        .HS_OFS(HS_OFS), .HS_W(HS_W), .VS_OFS(VS_OFS), .VS_W(VS_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ram_size(ram_size), .page_main(page_main),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .pix_out(pix_out), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .h_pos(h_pos), .v_pos(v_pos)
    );

    always #2 clk = ~clk;

    function automatic logic [23:0] size_of(input int code);
        case (code)
            0: return 24'h020000;
            1: return 24'h040000;
            2: return 24'h080000;
            3: return 24'h100000;
            4: return 24'h200000;
            5: return 24'h280000;
            default: return 24'h400000;
        endcase
    endfunction

    function automatic logic [15:0] mem_word(input logic [23:0] a);
        return (a[16:1] * 16'h9E37) ^ {a[23:16], a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0d", req, act, expv, t);
        end
    endtask

    // Per-cycle model and memory responder
    always @(negedge clk) begin
        if (running) begin
            int hp, vp, hm;
            bit rise, exp_req, exp_pix;
            hp = -H_BLANK + (t % LINE);
            vp = -V_BLANK + ((t / LINE) % VTOT);
            hm = ((hp % 16) + 16) % 16;
            // frame bookkeeping at line-0 entry (R6, R8)
            if (vp == 0 && hp == -H_BLANK) begin
                if (seen) chk(exp_idx == WPL * V_VIS, "R8 word count", exp_idx, WPL * V_VIS);
                fbase = size_of(int'(ram_size)) - (page_main ? 24'h5900 : 24'hD900);
                exp_idx = 0;
                seen = 1;
            end
            if (t == 0) begin
                chk(int'(h_pos) == -H_BLANK && int'(v_pos) == -V_BLANK, "R1 position", h_pos, -H_BLANK);
                chk(hsync_n && vsync_n && !pix_out && !fetch_req, "R1 outputs",
                    {hsync_n, vsync_n, pix_out, fetch_req}, 4'b1100);
            end
            chk(int'(h_pos) == hp, "R2 h_pos", h_pos, hp);
            chk(int'(v_pos) == vp, "R3 v_pos", v_pos, vp);
            chk(hsync_n == !(hp >= -H_BLANK + HS_OFS && hp < -H_BLANK + HS_OFS + HS_W),
                "R4 hsync_n", hsync_n, !hsync_n);
            chk(vsync_n == !(vp >= -V_BLANK + VS_OFS && vp < -V_BLANK + VS_OFS + VS_W),
                "R4 vsync_n", vsync_n, !vsync_n);
            exp_pix = 0;
            if (hp >= 0 && vp >= 0) begin
                logic [15:0] w;
                w = mem_word(fbase + 24'(2 * (vp * WPL + hp / 16)));
                exp_pix = w[15 - hm];
                chk(pix_out == exp_pix, "R9 pixel", pix_out, exp_pix);
            end else begin
                chk(pix_out == 1'b0, "R10 blank pixel", pix_out, 0);
            end
            rise = vp >= 0 && hm == 0 && hp >= -16 && hp <= H_VIS - 32;
            exp_req = outstanding || rise;
            chk(fetch_req == exp_req, "R7 request timing", fetch_req, exp_req);
            // responder
            if (fetch_ack) begin
                fetch_ack = 1'b0;
            end else if (fetch_req) begin
                wcnt++;
                if (wcnt >= lat) begin
                    chk(fetch_addr == fbase + 24'(2 * exp_idx), "R5 R7 R8 fetch address",
                        fetch_addr, fbase + 24'(2 * exp_idx));
                    exp_idx++;
                    fetch_ack = 1'b1;
                    fetch_data = mem_word(fetch_addr);
                    wcnt = 0;
                    acks++;
                    lat = 1 + (acks * 7) % 16;
                    exp_req = 0;
                end
            end
            outstanding = exp_req;
            // mid-frame input change, effective next frame only (R6)
            if (vp == 1 && hp == 0) begin
                fr++;
                ram_size = 3'(fr % 8);
                page_main = ((fr / 8) % 2) == 0;
            end
            t++;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(int'(h_pos) == -H_BLANK && !fetch_req && hsync_n && vsync_n, "R1 in reset", h_pos, -H_BLANK);
        rst_n = 1'b1;
        running = 1;
        repeat (FRAMES * LINE * VTOT) @(negedge clk);
        #1;
        running = 0;
        chk(fr >= 16, "R6 frames covered", fr, 16);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule